// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit with Tag-Overflow Trap

This unit adds or subtracts two words that are meant to hold tagged integers. In such a word the two least significant bits are a type tag, and zero means "small integer". The operation may go ahead only when both operands carry that zero tag and the signed result fits in the word. If either condition fails, the unit raises a tag-overflow trap. On a trap it withholds the write enable for the destination, and the condition-code register keeps its old contents.

The result, trap and write-enable outputs are combinational from the operand inputs. The four condition flags (negative, zero, overflow, carry) sit in a register. That register loads at a rising clock edge only when a valid operation completes without a trap. The surrounding pipeline supplies the operands and the add/subtract select. It then uses the trap to divert control flow and the write enable to gate its register-file write.

Top module: `tagged_arith_unit`

## Requirements
- R1: While reset is asserted and right after it is released, the flag register `nzvc` reads 4'b0000 (bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C).
- R2: `result` equals a + b modulo 2^32 when `op_sub` is 0, and a - b modulo 2^32 when `op_sub` is 1, in the same cycle as the inputs.
- R3: With `valid` high, `trap_tovf` is 1 whenever bit 0 or bit 1 of either operand is 1.
- R4: With `valid` high, `trap_tovf` is 1 whenever the signed 32-bit add or subtract overflows, even when both tags are zero.
- R5: With `valid` low, `trap_tovf` and `result_we` are both 0, whatever the operands are.
- R6: `result_we` is 1 exactly when `valid` is high and neither trap condition holds.
- R7: After a cycle in which `result_we` is 0, whether because of a trap or because `valid` is low, `nzvc` holds its previous value.
- R8: After a committed operation, N equals bit 31 of that result, and Z is 1 exactly when that result is zero.
- R9: After a committed operation, V is 0, because any overflow would have trapped.
- R10: After a committed add, C is 1 when the result is less than a as unsigned values. After a committed subtract, C is 1 when a is less than b as unsigned values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| valid | input | 1 | An operation is presented this cycle |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| a | input | 32 | First operand (minuend for subtract) |
| b | input | 32 | Second operand (subtrahend for subtract) |
| result | output | 32 | Sum or difference |
| result_we | output | 1 | Destination write enable; high only for a valid, trap-free operation |
| trap_tovf | output | 1 | Tag-overflow trap request |
| nzvc | output | 4 | Registered flags N, Z, V, C (bit 3 down to bit 0) |

## Verification
A nonzero tag and a signed overflow can occur in the same operation. Both must collapse into a single trap, with the write enable low and the flags frozen. The sweep forms operands from large-magnitude bases (near the positive and negative limits) with every tag combination ORed into the low bits. Many pairs therefore trip both conditions at once, while others trip only one or neither. For every pair and both operations, the bench computes the overflow independently with 33-bit signed arithmetic. It checks that the trap is the OR of the two causes and that the flags after the edge match its running model.

// File: rtl/tagged_arith_unit.sv
`timescale 1ns/1ps
module tagged_arith_unit #(
  parameter int W    = 32,
  parameter int TAGW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         op_sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         trap_tovf,
  output logic [3:0]   nzvc
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;
  logic [W-1:0] ovf_vec;
  logic         tag_bad, ovf, fault, c_next;

  assign b_eff   = op_sub ? ~b : b;
  assign wide    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, op_sub};
  assign result  = wide[W-1:0];

  assign tag_bad = |(a[TAGW-1:0] | b[TAGW-1:0]);
  assign ovf_vec = op_sub ? ((a ^ b) & (a ^ result))
                          : (~(a ^ b) & (a ^ result));
  assign ovf     = ovf_vec[MSB];
  assign fault   = tag_bad | ovf;

  assign c_next    = op_sub ? ~wide[W] : wide[W];
  assign trap_tovf = valid & fault;
  assign result_we = valid & ~fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      nzvc <= 4'b0000;
    else if (result_we)
      nzvc <= {result[MSB], ~|result, ovf, c_next};
  end

  // R3
  tag_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (|(a[TAGW-1:0] | b[TAGW-1:0]))) |-> (trap_tovf && !result_we));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!trap_tovf && !result_we));

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_we |=> $stable(nzvc));

  // R8
  nz_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |=> (nzvc[3] == $past(result[MSB])) && (nzvc[2] == ($past(result) == '0)));

  // R9
  v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |=> !nzvc[1]);

  // R6
  we_trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $countones({result_we, trap_tovf}) == 1);
endmodule

// File: tb/sim_tagged_arith_unit.sv
`timescale 1ns/1ps
module sim_tagged_arith_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [31:0] result;
  logic        result_we, trap_tovf;
  logic [3:0]  nzvc;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] exp_flags;

  always #2.5 clk = ~clk;

  tagged_arith_unit #(.W(32), .TAGW(2)) u0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op_sub(op_sub),
    .a(a), .b(b), .result(result), .result_we(result_we),
    .trap_tovf(trap_tovf), .nzvc(nzvc)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h sub=%0b actual=%h expected=%h", req, a, b, op_sub, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input int k);
    case (k)
      0: pick = 32'h0000_0000;
      1: pick = 32'h0000_0004;
      2: pick = 32'h7FFF_FFFC;
      3: pick = 32'h8000_0000;
      4: pick = 32'hFFFF_FFFC;
      5: pick = 32'h4000_0000;
      6: pick = 32'hC000_0000;
      default: pick = 32'h1234_5678;
    endcase
  endfunction

  task automatic run_op(input logic v, input logic s, input logic [31:0] av, input logic [31:0] bv);
    logic [31:0] r;
    logic signed [32:0] sx;
    logic tg, ov, cy;
    @(negedge clk);
    valid = v; op_sub = s; a = av; b = bv;
    r  = s ? av - bv : av + bv;
    sx = s ? $signed({av[31], av}) - $signed({bv[31], bv})
           : $signed({av[31], av}) + $signed({bv[31], bv});
    ov = sx[32] != sx[31];
    tg = ((av | bv) & 32'd3) != 0;
    cy = s ? (av < bv) : (r < av);
    #1;
    cmp("R2 result", result, r);
    if (!v) begin
      cmp("R5 trap idle", {31'd0, trap_tovf}, 32'd0);
      cmp("R5 we idle", {31'd0, result_we}, 32'd0);
    end else begin
      if (tg) cmp("R3 tag trap", {31'd0, trap_tovf}, 32'd1);
      else    cmp("R4 ovf trap", {31'd0, trap_tovf}, {31'd0, ov});
      cmp("R6 write enable", {31'd0, result_we}, {31'd0, !(tg || ov)});
    end
    if (v && !tg && !ov) exp_flags = {r[31], r == 32'd0, 1'b0, cy};
    @(posedge clk); #1;
    if (v && !tg && !ov) begin
      cmp("R8 N,Z", {30'd0, nzvc[3:2]}, {30'd0, exp_flags[3:2]});
      cmp("R9 V", {31'd0, nzvc[1]}, 32'd0);
      cmp("R10 C", {31'd0, nzvc[0]}, {31'd0, exp_flags[0]});
    end else begin
      cmp("R7 flags held", {28'd0, nzvc}, {28'd0, exp_flags});
    end
  endtask

  initial begin
    #750000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_flags = 4'b0000;
    #1;
    cmp("R1 reset flags", {28'd0, nzvc}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    cmp("R1 flags after release", {28'd0, nzvc}, 32'd0);
    // committed add with carry, then frozen by tag trap and idle cycles (R7, R10)
    run_op(1'b1, 1'b0, 32'hFFFF_FFFC, 32'h0000_0004);
    run_op(1'b1, 1'b0, 32'h0000_0001, 32'h0000_0004);
    run_op(1'b0, 1'b0, 32'h7FFF_FFFC, 32'h7FFF_FFFC);
    run_op(1'b0, 1'b1, 32'h0000_0003, 32'h0000_0000);
    // sweep: both trap causes alone and together
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        for (int s = 0; s < 2; s++)
          run_op(1'b1, s[0], pick(i / 4) | 32'(i % 4), pick(j / 4) | 32'(j % 4));
    // idle cycles with trapping operands
    for (int k = 0; k < 8; k++)
      run_op(1'b0, k[0], pick(k) | 32'd2, pick(7 - k));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule